// File: doc/BRIEF.md
# Serial EEPROM Slave with Block Write Protection

This block is a synthesizable behavioural model of a byte-wide serial EEPROM. It sits on an SPI bus as a slave. It runs from a local system clock and oversamples the SPI pins through a two-stage synchronizer. The storage is an internal register array. Its size is a parameter and may be 1024, 2048, 4096 or 8192 bytes.

A master controls the block with eight-bit opcodes. A read or a write opcode is followed by a 16-bit address, sent most significant bit first. A data write collects up to one page of bytes into a staging buffer. A timed programming cycle then copies the buffer into the array once chip select is released. Three gates guard every write: a software write-enable latch, two block-protect bits that lock the top of the array, and a write-protect pin that can freeze the status register. A hold pin pauses a transfer without losing its place.

Top module: `eep_spi_slave`

## Requirements
- R1: SI is sampled on rising SCK edges while chip select is low. Transfers behave the same whether SCK idles low (mode 0) or high (mode 3).
- R2: Opcode 0x03 followed by a 16-bit address returns array bytes on SO, MSB first, from consecutive addresses. The read wraps from the last address to address 0. Address bits above the array width are ignored.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. A data or status write sent while the latch is clear changes nothing.
- R4: Opcode 0x02 followed by an address and data bytes stores the bytes at consecutive addresses. When more bytes arrive than fit, the address wraps inside the same page (page size parameter, default 32).
- R5: Programming starts only if chip select rises right after a whole number of data bytes. Otherwise the array, the busy flag and the latch stay unchanged.
- R6: Opcode 0x05 returns the status byte, repeated for as long as clocks continue. Bit 0 is busy, bit 1 is the write-enable latch, bits 3:2 are the protect level, bit 7 enables the write-protect pin, and bits 6:4 read 0.
- R7: A started write keeps the busy flag high for WCYC system clocks. While busy, every opcode except 0x05 is ignored and SO stays disabled. When the cycle ends, the write-enable latch is cleared.
- R8: Protect level 00 locks nothing, 01 locks the upper quarter, 10 locks the upper half, and 11 locks the whole array. A write to a locked page starts no cycle and leaves the array and the latch as they were.
- R9: Opcode 0x01 with one data byte loads status bits 7 and 3:2 at the end of the cycle. It is refused while the write-protect pin is low and status bit 7 is 1.
- R10: While the hold pin is low, SCK edges are ignored and SO is disabled. After release, the transfer continues at the same bit.
- R11: After reset the status byte is 0x00, SO is disabled and every array byte reads 0xFF.
- R12: A programmed byte can be overwritten with a new value with no erase step in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data into the slave |
| wp_n | input | 1 | Write-protect pin, active low |
| hold_n | input | 1 | Hold pin, active low |
| so | output | 1 | Serial data out of the slave |
| so_en | output | 1 | Output enable for SO; 0 means SO is high-impedance |

## Verification
The bench aims at the write gates. These are a write sent before the latch is set, a write to a locked quarter or half, a status write with the protect pin low, and a write that stops three bits into a byte. A design that leaks through any of these gates shows a changed byte or status on read-back. Page overflow and array-end wrap are checked with addresses chosen so that a wrong wrap lands on a different, known value. A read sent during the busy window must leave SO disabled. A hold placed between two data bytes must resume with the next byte. A lost bit position would shift the byte that comes back.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDAT,
        PH_RDAT,
        PH_RSTAT,
        PH_WSTAT,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_DATA,
        K_STAT
    } kind_e;

    localparam logic [7:0] OP_WSET  = 8'h06;
    localparam logic [7:0] OP_WCLR  = 8'h04;
    localparam logic [7:0] OP_SREAD = 8'h05;
    localparam logic [7:0] OP_SLOAD = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int            N    = 5,
    parameter logic [N-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= INIT[i];
                s2_q <= INIT[i];
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/eep_guard.sv
module eep_guard (
    input  logic [1:0] region,
    input  logic [1:0] level,
    output logic       locked
);
    always_comb begin
        case (level)
            2'b00:   locked = 1'b0;
            2'b01:   locked = &region;
            2'b10:   locked = region[1];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave #(
    parameter int DEPTH = 1024,
    parameter int PAGE  = 32,
    parameter int WCYC  = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    input  logic hold_n,
    output logic so,
    output logic so_en
);
    import eep_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);
    localparam int CW = $clog2(WCYC + 1);

    typedef struct packed {
        phase_e                  ph;
        logic [3:0]              bc;
        logic [7:0]              sh;
        logic [15:0]             ad;
        logic                    rd;
        logic                    got;
        logic [7:0]              os;
        logic                    wel;
        logic [1:0]              bp;
        logic                    srwd;
        logic                    busy;
        logic [CW-1:0]           wc;
        kind_e                   kind;
        logic [7:0]              srn;
        logic [PAGE-1:0]         msk;
        logic [PAGE-1:0][7:0]    pb;
        logic                    sck_p;
        logic                    cs_p;
    } st_t;

    st_t q, d;
    logic commit_d;

    logic [4:0] pins_s;
    logic cs_s, sck_s, si_s, wp_s, hold_s;

    eep_sync #(.N(5), .INIT(5'b11001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hold_n, wp_n, si, sck, cs_n}),
        .q     (pins_s)
    );
    assign {hold_s, wp_s, si_s, sck_s, cs_s} = pins_s;

    logic locked;
    eep_guard u_guard (
        .region (q.ad[AW-1:AW-2]),
        .level  (q.bp),
        .locked (locked)
    );

    logic [7:0] mem [DEPTH];

    logic [7:0]    status;
    logic [15:0]   ad_in;
    logic [AW-1:0] ad_nxt;
    logic [7:0]    sh_in;
    logic [7:0]    mem_new, mem_nxt;
    logic          rise, cs_rise;

    always_comb begin
        status  = {q.srwd, 3'b000, q.bp, q.wel, q.busy};
        ad_in   = {q.ad[14:0], si_s};
        ad_nxt  = AW'(q.ad[AW-1:0] + 1'b1);
        sh_in   = {q.sh[6:0], si_s};
        mem_new = mem[ad_in[AW-1:0]];
        mem_nxt = mem[ad_nxt];
        rise    = sck_s && !q.sck_p;
        cs_rise = cs_s && !q.cs_p;
    end

    always_comb begin
        d        = q;
        commit_d = 1'b0;
        d.sck_p  = sck_s;
        d.cs_p   = cs_s;

        // self-timed cycle
        if (q.busy) begin
            if (q.wc == CW'(WCYC - 1)) begin
                d.busy   = 1'b0;
                d.wel    = 1'b0;
                d.kind   = K_NONE;
                commit_d = (q.kind == K_DATA);
                if (q.kind == K_STAT) begin
                    d.bp   = q.srn[3:2];
                    d.srwd = q.srn[7];
                end
            end else begin
                d.wc = CW'(q.wc + 1'b1);
            end
        end

        if (cs_s) begin
            d.ph  = PH_OPC;
            d.bc  = '0;
            d.got = 1'b0;
            if (cs_rise && q.bc[2:0] == 3'd0 && q.got && q.wel && !q.busy) begin
                if (q.ph == PH_WDAT && !locked) begin
                    d.busy = 1'b1;
                    d.wc   = '0;
                    d.kind = K_DATA;
                end else if (q.ph == PH_WSTAT && !(q.srwd && !wp_s)) begin
                    d.busy = 1'b1;
                    d.wc   = '0;
                    d.kind = K_STAT;
                end
            end
        end else if (rise && hold_s) begin
            d.sh = sh_in;
            d.bc = 4'(q.bc + 1'b1);
            case (q.ph)
                PH_OPC: if (q.bc == 4'd7) begin
                    d.bc = '0;
                    if (q.busy && sh_in != OP_SREAD) begin
                        d.ph = PH_SKIP;
                    end else begin
                        case (sh_in)
                            OP_WSET:  begin d.wel = 1'b1; d.ph = PH_SKIP; end
                            OP_WCLR:  begin d.wel = 1'b0; d.ph = PH_SKIP; end
                            OP_SREAD: begin d.os = status; d.ph = PH_RSTAT; end
                            OP_SLOAD: d.ph = PH_WSTAT;
                            OP_READ:  begin d.ph = PH_ADDR; d.rd = 1'b1; end
                            OP_WRITE: begin d.ph = PH_ADDR; d.rd = 1'b0; d.msk = '0; end
                            default:  d.ph = PH_SKIP;
                        endcase
                    end
                end
                PH_ADDR: begin
                    d.ad = ad_in;
                    if (q.bc == 4'd15) begin
                        d.bc = '0;
                        if (q.rd) begin
                            d.ph = PH_RDAT;
                            d.os = mem_new;
                        end else begin
                            d.ph = PH_WDAT;
                        end
                    end
                end
                PH_RDAT: begin
                    d.os = {q.os[6:0], 1'b0};
                    if (q.bc == 4'd7) begin
                        d.bc = '0;
                        d.ad[AW-1:0] = ad_nxt;
                        d.os = mem_nxt;
                    end
                end
                PH_RSTAT: begin
                    d.os = {q.os[6:0], 1'b0};
                    if (q.bc == 4'd7) begin
                        d.bc = '0;
                        d.os = status;
                    end
                end
                PH_WDAT: if (q.bc == 4'd7) begin
                    d.bc = '0;
                    d.pb[q.ad[PW-1:0]]  = sh_in;
                    d.msk[q.ad[PW-1:0]] = 1'b1;
                    d.got = 1'b1;
                    d.ad[PW-1:0] = PW'(q.ad[PW-1:0] + 1'b1);
                end
                PH_WSTAT: if (q.bc == 4'd7) begin
                    d.bc  = '0;
                    d.srn = sh_in;
                    d.got = 1'b1;
                end
                default: if (q.bc == 4'd7) d.bc = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_OPC;
            q.kind  <= K_NONE;
            q.cs_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit_d) begin
            for (int p = 0; p < PAGE; p++) begin
                if (q.msk[p]) mem[{q.ad[AW-1:PW], PW'(p)}] <= q.pb[p];
            end
        end
    end

    assign so    = q.os[7];
    assign so_en = !cs_s && hold_s && (q.ph == PH_RDAT || q.ph == PH_RSTAT);

    // R7
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.wel);

    // R3
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(q.wel));

    // R8
    prot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.busy) && q.kind == K_DATA) |-> !$past(locked));

    // R9
    sr_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({q.srwd, q.bp}) |-> ($past(q.busy) && !q.busy));

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !cs_s) |=> $stable(q.bc));

endmodule

// File: tb/sim_eep_spi_slave.sv
module sim_eep_spi_slave;
    localparam int WCYC = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
    logic so, so_en;

    int total = 0;
    int bad = 0;
    logic cpol = 1'b0;
    logic oe_seen;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    eep_spi_slave #(.DEPTH(1024), .PAGE(32), .WCYC(WCYC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .hold_n(hold_n), .so(so), .so_en(so_en)
    );

    // monitor: compares produced bytes against expected ones in order
    always @(negedge clk) begin
        if (exp_q.size() != 0 && got_q.size() != 0) begin
            logic [7:0] e, g;
            string t;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (g !== e) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", t, g, e);
            end
        end
    end

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    task automatic hc();
        repeat (5) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] ex);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, ex);
        end
    endtask

    task automatic expect_b(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic cs_begin();
        sck = cpol;
        oe_seen = 1'b0;
        hc();
        cs_n = 1'b0;
        hc(); hc();
    endtask

    task automatic cs_end();
        hc();
        sck = cpol;
        hc();
        cs_n = 1'b1;
        hc(); hc();
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            sck = 1'b0;
            si = tx[i];
            hc();
            rx[i] = so;
            if (so_en) oe_seen = 1'b1;
            sck = 1'b1;
            hc();
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] r;
        cs_begin(); xbyte(op, r); cs_end();
    endtask

    task automatic rdsr();
        logic [7:0] r;
        cs_begin(); xbyte(8'h05, r); xbyte(8'h00, r); got_q.push_back(r); cs_end();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        cs_begin(); xbyte(8'h01, r); xbyte(v, r); cs_end();
    endtask

    task automatic rd(input logic [15:0] a, input int n);
        logic [7:0] r;
        cs_begin();
        xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            got_q.push_back(r);
        end
        cs_end();
    endtask

    task automatic wr(input logic [15:0] a, input int n, input logic [7:0] b [4]);
        logic [7:0] r;
        cs_begin();
        xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int i = 0; i < n; i++) xbyte(b[i], r);
        cs_end();
    endtask

    task automatic settle();
        repeat (WCYC + 20) @(negedge clk);
    endtask

    initial begin
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11: reset state
        chk(so_en == 1'b0, "R11 so_en after reset", {7'd0, so_en}, 8'h00);
        expect_b(8'h00, "R11 status after reset"); rdsr();

        // R3: write without latch is ignored
        wr(16'h0010, 1, '{8'hAA, 8'h00, 8'h00, 8'h00});
        settle();
        expect_b(8'hFF, "R3 no-latch write ignored"); rd(16'h0010, 1);
        expect_b(8'h00, "R3 no cycle without latch"); rdsr();
        op1(8'h06);
        expect_b(8'h02, "R3 R6 latch set"); rdsr();
        op1(8'h04);
        expect_b(8'h00, "R3 latch cleared"); rdsr();

        // R7: busy window
        op1(8'h06);
        wr(16'h0020, 3, '{8'h11, 8'h22, 8'h33, 8'h00});
        expect_b(8'h03, "R7 busy and latch during cycle"); rdsr();
        cs_begin();
        xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h20, r); xbyte(8'h00, r);
        cs_end();
        chk(oe_seen == 1'b0, "R7 read ignored while busy", {7'd0, oe_seen}, 8'h00);
        settle();
        expect_b(8'h00, "R7 latch cleared after cycle"); rdsr();

        // R1: mode 3 read, R4 data stored
        cpol = 1'b1;
        expect_b(8'h11, "R1 R4 mode3 byte0");
        expect_b(8'h22, "R1 R4 mode3 byte1");
        expect_b(8'h33, "R1 R4 mode3 byte2");
        rd(16'h0020, 3);
        cpol = 1'b0;
        // R2: upper address bits ignored
        expect_b(8'h22, "R2 upper bits ignored"); rd(16'hFC21, 1);

        // R4 page wrap, R12 overwrite
        op1(8'h06);
        wr(16'h003E, 4, '{8'h01, 8'h02, 8'h03, 8'h04});
        settle();
        expect_b(8'h01, "R4 page end 0x3E");
        expect_b(8'h02, "R4 page end 0x3F");
        rd(16'h003E, 2);
        expect_b(8'h03, "R4 R12 wrapped 0x20");
        expect_b(8'h04, "R4 R12 wrapped 0x21");
        expect_b(8'h33, "R4 untouched 0x22");
        rd(16'h0020, 3);

        // R2: array-end wrap
        op1(8'h06); wr(16'h0000, 1, '{8'hA5, 8'h00, 8'h00, 8'h00}); settle();
        op1(8'h06); wr(16'h03FF, 1, '{8'h5A, 8'h00, 8'h00, 8'h00}); settle();
        expect_b(8'h5A, "R2 last address");
        expect_b(8'hA5, "R2 wrap to zero");
        rd(16'h03FF, 2);

        // R5: partial byte aborts
        op1(8'h06);
        cs_begin();
        xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h50, r); xbyte(8'h77, r);
        xbits(8'hE0, 3, r);
        cs_end();
        expect_b(8'h02, "R5 no cycle on partial byte"); rdsr();
        settle();
        expect_b(8'hFF, "R5 array unchanged"); rd(16'h0050, 1);
        op1(8'h04);

        // R8: protection levels
        op1(8'h06); wrsr(8'h04); settle();
        expect_b(8'h04, "R8 quarter level set"); rdsr();
        op1(8'h06);
        wr(16'h0300, 1, '{8'hC3, 8'h00, 8'h00, 8'h00});
        expect_b(8'h06, "R8 locked write starts no cycle"); rdsr();
        settle();
        expect_b(8'hFF, "R8 upper quarter locked"); rd(16'h0300, 1);
        wr(16'h02FF, 1, '{8'h3C, 8'h00, 8'h00, 8'h00});
        settle();
        expect_b(8'h3C, "R8 below quarter writable"); rd(16'h02FF, 1);
        op1(8'h06); wrsr(8'h08); settle();
        op1(8'h06);
        wr(16'h0200, 1, '{8'hC3, 8'h00, 8'h00, 8'h00});
        settle();
        expect_b(8'hFF, "R8 upper half locked"); rd(16'h0200, 1);
        op1(8'h06); wrsr(8'h0C); settle();
        op1(8'h06);
        wr(16'h0000, 1, '{8'h00, 8'h00, 8'h00, 8'h00});
        settle();
        expect_b(8'hA5, "R8 whole array locked"); rd(16'h0000, 1);

        // R9: write-protect pin on status
        op1(8'h06); wrsr(8'h80); settle();
        expect_b(8'h80, "R9 pin enable bit set"); rdsr();
        wp_n = 1'b0;
        op1(8'h06); wrsr(8'h0C); settle();
        expect_b(8'h82, "R9 status frozen by pin"); rdsr();
        wp_n = 1'b1;
        wrsr(8'h00); settle();
        expect_b(8'h00, "R9 status writable after release"); rdsr();

        // R10: hold between data bytes
        cs_begin();
        xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h20, r);
        xbyte(8'h00, r);
        expect_b(8'h03, "R10 byte before hold"); got_q.push_back(r);
        chk(so_en == 1'b1, "R10 so_en before hold", {7'd0, so_en}, 8'h01);
        hold_n = 1'b0;
        hc(); hc();
        chk(so_en == 1'b0, "R10 so_en during hold", {7'd0, so_en}, 8'h00);
        for (int i = 0; i < 5; i++) begin
            sck = 1'b0; si = 1'b1; hc();
            sck = 1'b1; hc();
        end
        chk(so_en == 1'b0, "R10 so_en still off", {7'd0, so_en}, 8'h00);
        hold_n = 1'b1;
        hc(); hc();
        xbyte(8'h00, r);
        expect_b(8'h04, "R10 resumed byte"); got_q.push_back(r);
        cs_end();

        repeat (10) @(negedge clk);
        if (exp_q.size() != 0 || got_q.size() != 0) begin
            chk(1'b0, "scoreboard leftover", 8'(got_q.size()), 8'(exp_q.size()));
        end
        finish_up();
    end
endmodule